// File: doc/BRIEF.md
# Clock-Recovery Loop Bandwidth Sequencer

This block chooses the loop bandwidth used by a receiver's bit-clock recovery loop. Normally it passes a 2-bit bandwidth setting, taken from a control register, straight to its output. A one-cycle "acquire" command replaces that setting for a while with a timed sequence: first a wide phase, then a medium phase, and finally a return to the register value. This lets the loop lock quickly onto a fresh transmission without software stepping in.

The sequence takes one of two paths. Which one depends on whether a frame-sync search is reported as started early enough after the command. If the search starts in time, the wide phase lasts until frame sync is found. If it does not, the wide phase has a fixed length counted in bit periods. Every count advances only on a strobe that marks one recovered bit period. While the block is in transmit mode it never runs a sequence, and its output simply follows the register.

Top module: `clkrec_bw_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `acq_active` is 0 and `bw_out` equals `bw_reg`. An `acq_cmd` that arrives during reset starts no sequence.
- R2: With no sequence active, `bw_out` equals `bw_reg` in every cycle. The codes are 00 = hold (loop frozen), 01 = narrow, 10 = medium and 11 = wide.
- R3: An `acq_cmd` pulse sampled while `tx_mode` is 0 takes effect on the next clock. From then on `acq_active` is 1 and `bw_out` is 11, and the 14-strobe decision window starts at zero.
- R4: If `srch_start` is not sampled before 14 `bit_stb` pulses have been counted since the command, `bw_out` stays 11 until the clock that samples the 16th strobe. After that clock it is 10. The strobes counted during the window are part of these 16.
- R5: If `srch_start` is sampled while fewer than 14 strobes have been counted, `bw_out` stays 11 for as many strobes as it takes, until `sync_found` is sampled.
- R6: After `sync_found` is sampled during a search-started wide phase, and after the 16th strobe of the fixed wide phase, `bw_out` is 10 for exactly 30 strobes. The clock that samples the 30th strobe clears `acq_active`, and `bw_out` returns to `bw_reg`.
- R7: A `srch_start` that arrives after the window has closed is ignored, and the fixed 16-strobe wide phase runs on unchanged.
- R8: Clock cycles without `bit_stb` do not advance any phase count.
- R9: An `acq_cmd` that arrives during a sequence, in any phase, restarts it from the beginning of the decision window.
- R10: `tx_mode` = 1 aborts any sequence at the next clock and blocks `acq_cmd`. When receive mode comes back, the sequence does not resume.
- R11: A `sync_found` that arrives before a search has started, or during the medium phase, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle pulse per recovered bit period |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| bw_reg | input | 2 | Bandwidth setting programmed in the register |
| acq_cmd | input | 1 | One-cycle acquire command |
| srch_start | input | 1 | A frame-sync search task has started |
| sync_found | input | 1 | Frame sync has been detected |
| bw_out | output | 2 | Active loop bandwidth code |
| acq_active | output | 1 | 1 while the acquire override is in control |

## Verification
The assertions check the rules that hold from one cycle to the next, on every cycle:
- the abort on transmit and the start on a command;
- that a cycle without a strobe freezes both the phase and its count;
- the move to medium when sync is found;
- the bounds on the window and medium counts;
- that the output is wide in every wide phase and follows the register whenever no sequence is active.

The exact phase lengths can only be shown by the bench's scenarios: 16 strobes of wide, 30 of medium, and a wide phase that runs on with no limit after an early search start. The same holds for the edge of the window at strobes 13 and 14, for restarts in every phase, and for sync or search events that are ignored.

// File: rtl/bwseq_pkg.sv
package bwseq_pkg;

    typedef enum logic [1:0] {
        BW_HOLD   = 2'b00,
        BW_NARROW = 2'b01,
        BW_MEDIUM = 2'b10,
        BW_WIDE   = 2'b11
    } bw_code_e;

    typedef enum logic [2:0] {
        PH_IDLE        = 3'd0,
        PH_WINDOW      = 3'd1,
        PH_FIXED_WIDE  = 3'd2,
        PH_SEARCH_WIDE = 3'd3,
        PH_MEDIUM      = 3'd4
    } phase_e;

endpackage

// File: rtl/bwseq_bit_counter.sv
module bwseq_bit_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> (cnt_o == $past(cnt_o)));

endmodule

// File: rtl/bwseq_phase_ctl.sv
module bwseq_phase_ctl
    import bwseq_pkg::*;
#(
    parameter int WIN_BITS  = 14,
    parameter int WIDE_BITS = 16,
    parameter int MED_BITS  = 30,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             rx_en,
    input  logic             acq_cmd,
    input  logic             srch_start,
    input  logic             sync_found,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output phase_e           phase_o
);

    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_BITS - 1);
    localparam logic [CNT_W-1:0] WIDE_LAST = CNT_W'(WIDE_BITS - 1);
    localparam logic [CNT_W-1:0] MED_LAST  = CNT_W'(MED_BITS - 1);
    localparam logic [CNT_W-1:0] WIN_LIM   = CNT_W'(WIN_BITS);
    localparam logic [CNT_W-1:0] MED_LIM   = CNT_W'(MED_BITS);

    typedef struct packed {
        phase_e phase;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!rx_en) begin
            st_d.phase = PH_IDLE;
            cnt_clr    = 1'b1;
        end else if (acq_cmd) begin
            st_d.phase = PH_WINDOW;
            cnt_clr    = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    cnt_clr = 1'b1;
                end
                PH_WINDOW: begin
                    if (srch_start) begin
                        st_d.phase = PH_SEARCH_WIDE;
                        cnt_clr    = 1'b1;
                    end else if (bit_stb) begin
                        cnt_inc = 1'b1;
                        if (cnt_i == WIN_LAST) begin
                            st_d.phase = PH_FIXED_WIDE;
                        end
                    end
                end
                PH_FIXED_WIDE: begin
                    if (bit_stb) begin
                        if (cnt_i == WIDE_LAST) begin
                            st_d.phase = PH_MEDIUM;
                            cnt_clr    = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                PH_SEARCH_WIDE: begin
                    if (sync_found) begin
                        st_d.phase = PH_MEDIUM;
                        cnt_clr    = 1'b1;
                    end
                end
                PH_MEDIUM: begin
                    if (bit_stb) begin
                        if (cnt_i == MED_LAST) begin
                            st_d.phase = PH_IDLE;
                            cnt_clr    = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    cnt_clr    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    // R10
    tx_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (phase_o == PH_IDLE));

    // R3
    acq_start_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && acq_cmd) |=> (phase_o == PH_WINDOW && cnt_i == '0));

    // R8
    no_stb_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !acq_cmd && !bit_stb &&
         (phase_o == PH_MEDIUM || phase_o == PH_FIXED_WIDE))
        |=> ($stable(phase_o) && $stable(cnt_i)));

    // R6
    found_to_medium_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !acq_cmd && phase_o == PH_SEARCH_WIDE && sync_found)
        |=> (phase_o == PH_MEDIUM && cnt_i == '0));

    // R4
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_WINDOW) |-> (cnt_i < WIN_LIM));

    // R6
    medium_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_MEDIUM) |-> (cnt_i < MED_LIM));

    // R7
    late_search_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !acq_cmd && phase_o == PH_FIXED_WIDE)
        |=> (phase_o != PH_SEARCH_WIDE));

endmodule

// File: rtl/bwseq_code_sel.sv
module bwseq_code_sel
    import bwseq_pkg::*;
(
    input  phase_e     phase_i,
    input  logic [1:0] bw_reg_i,
    output logic [1:0] bw_o,
    output logic       active_o
);

    bw_code_e code_d;

    always_comb begin
        unique case (phase_i)
            PH_WINDOW, PH_FIXED_WIDE, PH_SEARCH_WIDE: code_d = BW_WIDE;
            PH_MEDIUM:                                code_d = BW_MEDIUM;
            default:                                  code_d = bw_code_e'(bw_reg_i);
        endcase
    end

    assign bw_o     = code_d;
    assign active_o = (phase_i != PH_IDLE);

endmodule

// File: rtl/clkrec_bw_sequencer.sv
module clkrec_bw_sequencer
    import bwseq_pkg::*;
#(
    parameter int WIN_BITS  = 14,
    parameter int WIDE_BITS = 16,
    parameter int MED_BITS  = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       tx_mode,
    input  logic [1:0] bw_reg,
    input  logic       acq_cmd,
    input  logic       srch_start,
    input  logic       sync_found,
    output logic [1:0] bw_out,
    output logic       acq_active
);

    localparam int MAX_BITS = (WIDE_BITS > MED_BITS) ? WIDE_BITS : MED_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;
    phase_e           phase;

    bwseq_bit_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt_o (cnt)
    );

    bwseq_phase_ctl #(
        .WIN_BITS  (WIN_BITS),
        .WIDE_BITS (WIDE_BITS),
        .MED_BITS  (MED_BITS),
        .CNT_W     (CNT_W)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .rx_en      (!tx_mode),
        .acq_cmd    (acq_cmd),
        .srch_start (srch_start),
        .sync_found (sync_found),
        .cnt_i      (cnt),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .phase_o    (phase)
    );

    bwseq_code_sel u_sel (
        .phase_i  (phase),
        .bw_reg_i (bw_reg),
        .bw_o     (bw_out),
        .active_o (acq_active)
    );

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !acq_active |-> (bw_out == bw_reg));

    // R3
    wide_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WINDOW || phase == PH_FIXED_WIDE || phase == PH_SEARCH_WIDE)
        |-> (bw_out == 2'b11 && acq_active));

    // R10
    tx_blocks_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && acq_cmd) |=> !acq_active);

endmodule

// File: tb/clkrec_bw_sequencer_test.sv
module clkrec_bw_sequencer_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       tx_mode = 1'b0;
    logic [1:0] bw_reg = 2'b10;
    logic       acq_cmd = 1'b0;
    logic       srch_start = 1'b0;
    logic       sync_found = 1'b0;
    logic [1:0] bw_out;
    logic       acq_active;

    logic       cur_rst = 1'b1;
    logic       cur_tx  = 1'b0;
    logic [1:0] cur_reg = 2'b10;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [1:0] exp_out_q[$];
    logic       exp_act_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkrec_bw_sequencer uut (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .tx_mode    (tx_mode),
        .bw_reg     (bw_reg),
        .acq_cmd    (acq_cmd),
        .srch_start (srch_start),
        .sync_found (sync_found),
        .bw_out     (bw_out),
        .acq_active (acq_active)
    );

    // Driver: applies one cycle of inputs and queues what must appear after the next edge.
    task automatic drive(input logic s, input logic c, input logic ss, input logic sf,
                         input logic [1:0] eo, input logic ea, input string tag);
        @(negedge clk);
        rst        = cur_rst;
        tx_mode    = cur_tx;
        bw_reg     = cur_reg;
        bit_stb    = s;
        acq_cmd    = c;
        srch_start = ss;
        sync_found = sf;
        exp_out_q.push_back(eo);
        exp_act_q.push_back(ea);
        tag_q.push_back(tag);
    endtask

    // n bit periods (strobe cycle plus a gap cycle each); the last strobe gets its own expectation.
    task automatic bits(input int n, input logic [1:0] em, input logic am,
                        input logic [1:0] el, input logic al, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [1:0] eo;
            logic       ea;
            eo = (i == n - 1) ? el : em;
            ea = (i == n - 1) ? al : am;
            drive(1'b1, 1'b0, 1'b0, 1'b0, eo, ea, tag);
            drive(1'b0, 1'b0, 1'b0, 1'b0, eo, ea, tag);
        end
    endtask

    task automatic cmd(input string tag);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, tag);
    endtask

    // Monitor: compares after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_out_q.size() > 0) begin
            logic [1:0] eo;
            logic       ea;
            string      tg;
            eo = exp_out_q.pop_front();
            ea = exp_act_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (bw_out !== eo || acq_active !== ea) begin
                fails++;
                $display("FAIL %s: bw_out=%b acq_active=%b expected bw_out=%b acq_active=%b at %0t",
                         tg, bw_out, acq_active, eo, ea, $time);
            end
        end
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                done = 1'b1;
                fails++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state, command ignored in reset
        cur_rst = 1'b1; cur_reg = 2'b10;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, "R1");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, "R1");
        cur_rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, "R1");

        // R2: every register code passes through
        for (int v = 0; v < 4; v++) begin
            cur_reg = 2'(v);
            drive(1'b0, 1'b0, 1'b0, 1'b0, 2'(v), 1'b0, "R2");
            drive(1'b1, 1'b0, 1'b0, 1'b0, 2'(v), 1'b0, "R2");
        end

        // R4 / R6: no search, 16 wide then 30 medium
        cur_reg = 2'b01;
        cmd("R3");
        bits(16, 2'b11, 1'b1, 2'b10, 1'b1, "R4");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R6");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R2");

        // R5 / R6: early search, wide past 16 strobes until sync
        cur_reg = 2'b00;
        cmd("R3");
        bits(5, 2'b11, 1'b1, 2'b11, 1'b1, "R5");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, "R5");
        bits(40, 2'b11, 1'b1, 2'b11, 1'b1, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, "R6");
        bits(30, 2'b10, 1'b1, 2'b00, 1'b0, "R6");

        // R5 boundary: search after 13 strobes still counts
        cur_reg = 2'b01;
        cmd("R3");
        bits(13, 2'b11, 1'b1, 2'b11, 1'b1, "R5");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, "R5");
        bits(10, 2'b11, 1'b1, 2'b11, 1'b1, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, "R6");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R6");

        // R7: search after 14 strobes ignored; R11: sync during medium ignored
        cur_reg = 2'b10;
        cmd("R3");
        bits(14, 2'b11, 1'b1, 2'b11, 1'b1, "R7");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, "R7");
        bits(2, 2'b11, 1'b1, 2'b10, 1'b1, "R7");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, "R11");
        bits(30, 2'b10, 1'b1, 2'b10, 1'b0, "R11");

        // R11: sync before any search ignored
        cur_reg = 2'b01;
        cmd("R3");
        bits(3, 2'b11, 1'b1, 2'b11, 1'b1, "R11");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, "R11");
        bits(13, 2'b11, 1'b1, 2'b10, 1'b1, "R11");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R11");

        // R8: long gaps between strobes do not advance
        cmd("R3");
        for (int g = 0; g < 20; g++) drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R8");
        bits(16, 2'b11, 1'b1, 2'b10, 1'b1, "R8");
        for (int g = 0; g < 20; g++) drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, "R8");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R8");

        // R9: restart in window and in medium
        cmd("R3");
        bits(10, 2'b11, 1'b1, 2'b11, 1'b1, "R9");
        cmd("R9");
        bits(16, 2'b11, 1'b1, 2'b10, 1'b1, "R9");
        bits(10, 2'b10, 1'b1, 2'b10, 1'b1, "R9");
        cmd("R9");
        bits(16, 2'b11, 1'b1, 2'b10, 1'b1, "R9");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R9");

        // R9: restart in search-wide phase returns to window
        cmd("R3");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, "R9");
        cmd("R9");
        bits(16, 2'b11, 1'b1, 2'b10, 1'b1, "R9");
        bits(30, 2'b10, 1'b1, 2'b01, 1'b0, "R9");

        // R10: transmit aborts, blocks command, no resume
        cur_reg = 2'b11;
        cmd("R3");
        bits(5, 2'b11, 1'b1, 2'b11, 1'b1, "R10");
        cur_reg = 2'b00;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R10");
        cur_tx = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R10");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, "R10");
        bits(20, 2'b00, 1'b0, 2'b00, 1'b0, "R10");
        cur_tx = 1'b0;
        bits(3, 2'b00, 1'b0, 2'b00, 1'b0, "R10");

        // R10: abort during search; later sync does nothing
        cur_reg = 2'b01;
        cmd("R3");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, "R10");
        cur_tx = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R10");
        cur_tx = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, "R10");

        // R1: reset mid-sequence
        cmd("R3");
        bits(3, 2'b11, 1'b1, 2'b11, 1'b1, "R1");
        cur_rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R1");
        cur_rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R1");

        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule